// File: doc/BRIEF.md
# Universal Shift Register with Bidirectional Port

This block is a storage register with a parameterised width of eight bits by default. On every rising clock edge it does one of four things, chosen by a two-bit select. It can keep its contents, shift toward the top bit, shift toward the bottom bit, or capture a full word from its parallel port. Each shift direction takes its new end bit from its own serial input. The bottom bit and the top bit each also appear on a serial output that is never disabled. Several units can therefore be chained, or one unit can feed its top bit back to its own bottom input to rotate its contents.

The parallel port is a bidirectional bus. It is modelled as a data input, a data output and one drive enable. The port drives the register contents only when both active-low output enables are low and the select is not the load code. Selecting the load code turns the bus into an input, whatever the enables say. An active-low clear empties the register at once, without waiting for a clock, and it wins over every other input.

No valid/ready handshake is used anywhere. The register accepts a new operation on every edge and never stalls, so there is no back-pressure to express. All pins are therefore plain control and data pins.

Top module: `usr_shift_reg`

## Requirements
- R1: With select 2'b00 a rising edge leaves every bit of the register unchanged.
- R2: With select 2'b01 a rising edge moves bit i into bit i+1 and puts `ser_lo_in` into bit 0.
- R3: While `rst_n` is low the register reads all zeros, at once and with no clock edge, whatever the select and data inputs are.
- R4: With select 2'b10 a rising edge moves bit i+1 into bit i and puts `ser_hi_in` into bit WIDTH-1.
- R5: With select 2'b11 a single rising edge copies `io_in` into the register, whatever the state of `oe_a_n` and `oe_b_n`.
- R6: `io_oe` is high exactly when `oe_a_n` and `oe_b_n` are both low and the select is not 2'b11.
- R7: `io_out` always carries the current register contents, with bit i of `io_out` equal to register bit i.
- R8: `ser_lo_out` equals register bit 0 and `ser_hi_out` equals register bit WIDTH-1, whatever the output enables are.
- R9: With `ser_hi_out` wired back to `ser_lo_in`, WIDTH shifts with select 2'b01 restore the original contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| sel | input | 2 | Mode select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_lo_in | input | 1 | Serial bit that enters bit 0 when shifting up |
| ser_hi_in | input | 1 | Serial bit that enters the top bit when shifting down |
| oe_a_n | input | 1 | First active-low output enable |
| oe_b_n | input | 1 | Second active-low output enable |
| io_in | input | WIDTH | Value sensed on the shared port pins |
| io_out | output | WIDTH | Value the port drives when enabled |
| io_oe | output | 1 | Drive enable for the shared port |
| ser_lo_out | output | 1 | Bit 0, always driven |
| ser_hi_out | output | 1 | Top bit, always driven |

## Verification
Two functions can land in the same cycle. A parallel load can be requested while both output enables are low, so the port turns around to input in the same cycle that it would otherwise drive. The bench provokes this and expects `io_oe` low together with the loaded word on the following edge. The clear can also be pulled low between edges while a load is selected with fresh data on `io_in`. The bench then expects zero contents both before and after the next edge, which shows that the clear overrides the load.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;
endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
  import usr_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output usr_mode_e  mode,
  output logic       port_drive
);
  logic enables_low;

  always_comb begin
    mode        = usr_mode_e'(sel);
    enables_low = ~oe_a_n & ~oe_b_n;
    port_drive  = enables_low & (mode != MODE_LOAD);
  end

  // The bus must never drive while it is taking in a word (R5, R6).
  always_comb begin
    if (sel == 2'b11) begin
      assert_no_drive_in_load_R6: assert (!port_drive);
    end
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell
  import usr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  usr_mode_e mode,
  input  logic      from_lo,
  input  logic      from_hi,
  input  logic      par_in,
  output logic      q
);
  logic q_nxt;

  always_comb begin
    unique case (mode)
      MODE_HOLD: q_nxt = q;
      MODE_UP:   q_nxt = from_lo;
      MODE_DOWN: q_nxt = from_hi;
      MODE_LOAD: q_nxt = par_in;
      default:   q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sel,
  input  logic             ser_lo_in,
  input  logic             ser_hi_in,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] io_in,
  output logic [WIDTH-1:0] io_out,
  output logic             io_oe,
  output logic             ser_lo_out,
  output logic             ser_hi_out
);
  localparam int TOP = WIDTH - 1;

  usr_mode_e        mode;
  logic [WIDTH-1:0] q;

  usr_ctrl u_ctrl (
    .sel       (sel),
    .oe_a_n    (oe_a_n),
    .oe_b_n    (oe_b_n),
    .mode      (mode),
    .port_drive(io_oe)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic lo_src;
    logic hi_src;
    if (i == 0) begin : g_first
      assign lo_src = ser_lo_in;
    end else begin : g_mid_lo
      assign lo_src = q[i-1];
    end
    if (i == TOP) begin : g_last
      assign hi_src = ser_hi_in;
    end else begin : g_mid_hi
      assign hi_src = q[i+1];
    end
    usr_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .from_lo(lo_src),
      .from_hi(hi_src),
      .par_in (io_in[i]),
      .q      (q[i])
    );
  end

  assign io_out     = q;
  assign ser_lo_out = q[0];
  assign ser_hi_out = q[TOP];

  assert_hold_keeps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'b00 |=> $stable(q));

  assert_shift_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'b01 |=> q == {$past(q[TOP-1:0]), $past(ser_lo_in)});

  assert_shift_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'b10 |=> q == {$past(ser_hi_in), $past(q[TOP:1])});

  assert_load_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 2'b11 |=> q == $past(io_in));

  assert_drive_needs_enables_R6: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> (!oe_a_n && !oe_b_n));
endmodule

// File: tb/test_usr_shift_reg.sv
module test_usr_shift_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic         lo_reg = 1'b0;
  logic         ser_hi_in = 1'b0;
  logic         oe_a_n = 1'b1;
  logic         oe_b_n = 1'b1;
  logic [W-1:0] io_in = '0;
  logic         recirc = 1'b0;
  logic         ser_lo_in;
  logic [W-1:0] io_out;
  logic         io_oe;
  logic         ser_lo_out;
  logic         ser_hi_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign ser_lo_in = recirc ? ser_hi_out : lo_reg;

  usr_shift_reg #(.WIDTH(W)) i_usr_shift_reg (
    .clk(clk), .rst_n(rst_n), .sel(sel), .ser_lo_in(ser_lo_in),
    .ser_hi_in(ser_hi_in), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .ser_lo_out(ser_lo_out), .ser_hi_out(ser_hi_out)
  );

  typedef struct {
    logic [W-1:0] q;
    logic         oe;
    string        tag;
  } exp_t;

  exp_t         sb[$];
  logic [W-1:0] model = '0;

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] s, input logic lo, input logic hi,
                      input logic [W-1:0] d, input logic oa, input logic ob,
                      input string tag);
    exp_t e;
    @(negedge clk);
    sel = s; lo_reg = lo; ser_hi_in = hi; io_in = d; oe_a_n = oa; oe_b_n = ob;
    @(posedge clk);
    case (s)
      2'b01: model = {model[W-2:0], (recirc ? model[W-1] : lo)};
      2'b10: model = {hi, model[W-1:1]};
      2'b11: model = d;
      default: model = model;
    endcase
    e.q   = model;
    e.oe  = !oa && !ob && (s != 2'b11);
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        check({e.tag, " io_out R7"}, io_out, e.q);
        check({e.tag, " io_oe R6"}, {{(W-1){1'b0}}, io_oe}, {{(W-1){1'b0}}, e.oe});
        check({e.tag, " serial outs R8"}, {{(W-2){1'b0}}, ser_hi_out, ser_lo_out},
              {{(W-2){1'b0}}, e.q[W-1], e.q[0]});
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [W-1:0] orig;
    #20;
    check("R3 reset state", io_out, '0);
    @(negedge clk);
    rst_n = 1'b1;

    step(2'b11, 0, 0, 8'hA5, 0, 0, "R5 load with enables low");
    step(2'b00, 1, 1, 8'h3C, 0, 0, "R1 hold enabled");
    step(2'b00, 0, 0, 8'hFF, 1, 0, "R1 hold oe_a high");
    step(2'b00, 0, 0, 8'h00, 0, 1, "R6 hold oe_b high");
    step(2'b01, 1, 0, 8'h00, 0, 0, "R2 shift up in 1");
    step(2'b01, 0, 1, 8'hFF, 1, 1, "R2 shift up in 0");
    step(2'b01, 1, 0, 8'h00, 0, 0, "R2 shift up in 1 again");
    step(2'b10, 0, 1, 8'h00, 0, 0, "R4 shift down in 1");
    step(2'b10, 1, 0, 8'h00, 1, 0, "R4 shift down in 0");
    step(2'b11, 0, 0, 8'h5A, 1, 1, "R5 load with enables high");
    step(2'b10, 0, 0, 8'h00, 0, 0, "R4 shift down drains");
    step(2'b11, 0, 0, 8'h81, 0, 1, "R5 load ends set R8");

    step(2'b11, 0, 0, 8'h96, 0, 0, "R9 preload");
    orig = 8'h96;
    @(negedge clk);
    recirc = 1'b1;
    for (int k = 0; k < W; k++) step(2'b01, 0, 0, 8'h00, 0, 0, "R9 rotate");
    @(negedge clk);
    recirc = 1'b0;
    sel = 2'b00;
    check("R9 contents restored", io_out, orig);

    @(negedge clk);
    sel = 2'b11; io_in = 8'hE7;
    #1 rst_n = 1'b0;
    #1 check("R3 clear between edges", io_out, '0);
    @(posedge clk);
    #2 check("R3 clear beats load", io_out, '0);
    @(negedge clk);
    sel = 2'b00;
    rst_n = 1'b1;
    model = '0;
    step(2'b00, 0, 0, 8'h00, 0, 0, "R1 hold after clear");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule